// File: doc/BRIEF.md
# Data/Strobe Link Character Codec

This block turns a stream of host words into link characters and drives them onto a two-wire data/strobe pair. It also decodes the same kind of pair in the other direction. A host word can be a data byte or a packet terminator, and a separate request input asks for a flow-control token. The transmitter frames each character with a parity bit and a data/control flag, then shifts the bits out one per bit period. The bit period comes from a prescaler of the reference clock, and a two-bit rate select picks one of four divisors while the block runs.

The receive half samples the two incoming wires on the reference clock. It takes a new bit each time the XOR of data and strobe toggles, so it follows whatever rate the far end uses. It rebuilds each character, checks its parity and delivers data bytes, terminators and flow-control tokens. A parity failure stops reception until the next reset.

Top module: `dsl_link_codec`

## Requirements
- R1: While reset is asserted and right after it is released, tx_d and tx_s are 0, tx_ready and fct_ready are 1, rx_valid and rx_fct are 0 and rx_par_err is 0. Reset also clears a latched parity error.
- R2: In each bit period exactly one of tx_d and tx_s changes. tx_d carries the bit value, and tx_s toggles only when the bit equals the previous bit.
- R3: A character goes out in this order: parity bit, then flag, then payload least significant bit first. A data character has flag 0 and 8 payload bits. A control character has flag 1 and 2 payload bits.
- R4: Parity is odd. The parity bit, the payload bits of the previous character and the flag of the current character together hold an odd number of ones. For the first character after reset, the previous payload counts as all zeros.
- R5: Control codes are 00 flow-control token, 01 end of packet, 10 error end of packet and 11 escape, with code bit 0 sent first. A host word with bit 8 set sends end of packet when bit 0 is 0 and error end of packet when bit 0 is 1. Bits 7:1 of such a word are ignored.
- R6: When fct_req and tx_valid are both high while the shifter is empty, the flow-control token is sent first. tx_ready stays low for as long as fct_req is high.
- R7: rate_sel values 0, 1, 2 and 3 select bit periods of DIV_R0, DIV_R1, DIV_R2 and DIV_R3 reference cycles (defaults 2, 4, 20, 40, which at 200 MHz give 100, 50, 10 and 5 Mb/s). A new selection applies from the next bit.
- R8: A word is taken on a cycle with valid and ready both high. Ready is high only while the shifter is empty. A host that keeps words available gets characters back to back, one bit period apart, with no idle period between them.
- R9: The receiver delivers data as rx_word with bit 8 = 0, end of packet as 9'h100 and error end of packet as 9'h101, each with a one-cycle rx_valid pulse. A flow-control token gives a one-cycle rx_fct pulse. Each result appears SYNC_STAGES+1 cycles after the line edge that carries the last bit.
- R10: When a parity check fails, rx_par_err goes high and stays high until reset. The failing character and all later characters are not delivered.
- R11: The receiver takes a bit on every toggle of data XOR strobe and does not depend on any bit period. Characters with uneven bit lengths decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Line rate select |
| tx_valid | input | 1 | Host word available |
| tx_ready | output | 1 | Host word accepted this cycle if valid |
| tx_word | input | 9 | Host word; bit 8 marks a packet terminator |
| fct_req | input | 1 | Request to send a flow-control token |
| fct_ready | output | 1 | Token request accepted this cycle |
| tx_d | output | 1 | Transmit data line |
| tx_s | output | 1 | Transmit strobe line |
| rx_d | input | 1 | Receive data line |
| rx_s | input | 1 | Receive strobe line |
| rx_valid | output | 1 | One-cycle pulse with a received word |
| rx_word | output | 9 | Received data byte or terminator |
| rx_fct | output | 1 | One-cycle pulse for a received token |
| rx_par_err | output | 1 | Latched parity error |

## Verification
The first bit of a character appears on the next prescaler tick after the word is accepted. Each later line transition comes exactly one selected bit period after the previous one. The bench therefore logs every line transition with its cycle number and checks the spacing between transitions, not absolute times, for both rate selection and back-to-back streaming. On the receive side, rx_valid rises three cycles after the edge of the last bit at the default synchroniser depth. One directed test drives that final edge on a known falling clock edge and expects the pulse on exactly the third falling edge, and nowhere else. Other received results are collected by a monitor and compared in order after a settle window much longer than that latency.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
   localparam int unsigned DATA_BITS = 8;
   localparam int unsigned CTRL_BITS = 2;

   typedef enum logic [CTRL_BITS-1:0] {
      CTRL_FCT = 2'b00,
      CTRL_EOP = 2'b01,
      CTRL_EEP = 2'b10,
      CTRL_ESC = 2'b11
   } ctrl_code_e;

   typedef enum logic [1:0] {
      RX_PAR  = 2'd0,
      RX_FLAG = 2'd1,
      RX_PAY  = 2'd2
   } rx_phase_e;
endpackage

// File: rtl/dsl_prescaler.sv
module dsl_prescaler #(
   parameter int unsigned DIV_R0 = 2,
   parameter int unsigned DIV_R1 = 4,
   parameter int unsigned DIV_R2 = 20,
   parameter int unsigned DIV_R3 = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_sel,
   output logic       tick
);
   localparam int unsigned M01  = (DIV_R0 > DIV_R1) ? DIV_R0 : DIV_R1;
   localparam int unsigned M23  = (DIV_R2 > DIV_R3) ? DIV_R2 : DIV_R3;
   localparam int unsigned DMAX = (M01 > M23) ? M01 : M23;
   localparam int unsigned CW   = $clog2(DMAX);
   localparam logic [CW-1:0] RELOAD [4] = '{CW'(DIV_R0 - 1), CW'(DIV_R1 - 1),
                                            CW'(DIV_R2 - 1), CW'(DIV_R3 - 1)};

   generate
      if (DIV_R0 < 2 || DIV_R1 < 2 || DIV_R2 < 2 || DIV_R3 < 2) begin : g_bad_div
         $error("dsl_prescaler: every divisor must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt == '0) begin
         cnt <= RELOAD[rate_sel];
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign tick = (cnt == '0);

   // R7: ticks are never adjacent, so every bit lasts at least two cycles
   p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/dsl_tx_shift.sv
module dsl_tx_shift
   import dsl_pkg::*;
#(
   parameter int unsigned DW = DATA_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ld,
   input  logic          ld_ctrl,
   input  logic [DW-1:0] ld_bits,
   output logic          empty,
   output logic          d_out,
   output logic          s_out
);
   localparam int unsigned CB   = CTRL_BITS;
   localparam int unsigned SW   = DW + 2;
   localparam int unsigned CNTW = $clog2(SW + 1);

   generate
      if (DW < CB) begin : g_bad_width
         $error("dsl_tx_shift: payload narrower than a control code");
      end
   endgenerate

   logic [SW-1:0]   sh;
   logic [CNTW-1:0] cnt;
   logic            prev_par;
   logic [SW-1:0]   frame;
   logic            par_bit;
   logic            pay_par;

   always_comb begin
      pay_par = ld_ctrl ? ^ld_bits[CB-1:0] : ^ld_bits;
      par_bit = ~(prev_par ^ ld_ctrl);
      frame   = '0;
      if (ld_ctrl) begin
         frame[CB+1:0] = {ld_bits[CB-1:0], 1'b1, par_bit};
      end else begin
         frame = {ld_bits, 1'b0, par_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         prev_par <= 1'b0;
         d_out    <= 1'b0;
         s_out    <= 1'b0;
      end else if (ld) begin
         sh       <= frame;
         cnt      <= ld_ctrl ? CNTW'(CB + 2) : CNTW'(SW);
         prev_par <= pay_par;
      end else if (tick && cnt != '0) begin
         d_out <= sh[0];
         s_out <= s_out ^ ~(sh[0] ^ d_out);
         sh    <= sh >> 1;
         cnt   <= cnt - 1'b1;
      end
   end

   assign empty = (cnt == '0);

   // R2: the two lines never change in the same cycle
   p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !((d_out != $past(d_out)) && (s_out != $past(s_out))));

   // R8: a loaded character makes the shifter busy on the next cycle
   p_busy_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> !empty);
endmodule

// File: rtl/dsl_rx_decode.sv
module dsl_rx_decode
   import dsl_pkg::*;
#(
   parameter int unsigned DW   = DATA_BITS,
   parameter int unsigned SYNC = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        d_in,
   input  logic        s_in,
   output logic        rx_valid,
   output logic [DW:0] rx_word,
   output logic        rx_fct,
   output logic        par_err
);
   localparam int unsigned CB = CTRL_BITS;
   localparam int unsigned LW = $clog2(DW + 1);

   logic d_sy, s_sy;

   generate
      if (SYNC > 4) begin : g_bad_sync
         $error("dsl_rx_decode: at most four synchroniser stages");
      end
      if (SYNC == 0) begin : g_nosync
         assign d_sy = d_in;
         assign s_sy = s_in;
      end else begin : g_sync
         logic [SYNC-1:0] dq, sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dq <= '0;
               sq <= '0;
            end else begin
               dq <= SYNC'({dq, d_in});
               sq <= SYNC'({sq, s_in});
            end
         end
         assign d_sy = dq[SYNC-1];
         assign s_sy = sq[SYNC-1];
      end
   endgenerate

   rx_phase_e       ph;
   logic            x_prev;
   logic            p_q;
   logic            f_q;
   logic            prev_par;
   logic [DW-1:0]   pay;
   logic [LW-1:0]   left;
   logic            evt;
   logic [DW-1:0]   next_pay;
   logic [CB-1:0]   code;

   assign evt      = ((d_sy ^ s_sy) != x_prev);
   assign next_pay = {d_sy, pay[DW-1:1]};
   assign code     = next_pay[DW-1 -: CB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= RX_PAR;
         x_prev   <= 1'b0;
         p_q      <= 1'b0;
         f_q      <= 1'b0;
         prev_par <= 1'b0;
         pay      <= '0;
         left     <= '0;
         rx_valid <= 1'b0;
         rx_word  <= '0;
         rx_fct   <= 1'b0;
         par_err  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_fct   <= 1'b0;
         x_prev   <= d_sy ^ s_sy;
         if (evt && !par_err) begin
            case (ph)
               RX_PAR: begin
                  p_q <= d_sy;
                  ph  <= RX_FLAG;
               end
               RX_FLAG: begin
                  if ((p_q ^ d_sy ^ prev_par) == 1'b0) begin
                     par_err <= 1'b1;
                     ph      <= RX_PAR;
                  end else begin
                     f_q  <= d_sy;
                     left <= d_sy ? LW'(CB) : LW'(DW);
                     pay  <= '0;
                     ph   <= RX_PAY;
                  end
               end
               default: begin
                  pay  <= next_pay;
                  left <= left - 1'b1;
                  if (left == LW'(1)) begin
                     ph <= RX_PAR;
                     if (!f_q) begin
                        prev_par <= ^next_pay;
                        rx_valid <= 1'b1;
                        rx_word  <= {1'b0, next_pay};
                     end else begin
                        prev_par <= ^code;
                        case (ctrl_code_e'(code))
                           CTRL_FCT: rx_fct <= 1'b1;
                           CTRL_EOP: begin
                              rx_valid <= 1'b1;
                              rx_word  <= {1'b1, {DW{1'b0}}};
                           end
                           CTRL_EEP: begin
                              rx_valid <= 1'b1;
                              rx_word  <= {1'b1, {(DW-1){1'b0}}, 1'b1};
                           end
                           default: ;
                        endcase
                     end
                  end
               end
            endcase
         end
      end
   end

   // R10: a parity error stays latched until reset
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> par_err);

   // R10: nothing is delivered while the error is latched
   p_quiet_after_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |-> (!rx_valid && !rx_fct));

   // R9: one result kind per cycle
   p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_fct));
endmodule

// File: rtl/dsl_link_codec.sv
module dsl_link_codec
   import dsl_pkg::*;
#(
   parameter int unsigned DIV_R0      = 2,
   parameter int unsigned DIV_R1      = 4,
   parameter int unsigned DIV_R2      = 20,
   parameter int unsigned DIV_R3      = 40,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           rate_sel,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   input  logic [DATA_BITS:0]   tx_word,
   input  logic                 fct_req,
   output logic                 fct_ready,
   output logic                 tx_d,
   output logic                 tx_s,
   input  logic                 rx_d,
   input  logic                 rx_s,
   output logic                 rx_valid,
   output logic [DATA_BITS:0]   rx_word,
   output logic                 rx_fct,
   output logic                 rx_par_err
);
   localparam int unsigned DW = DATA_BITS;
   localparam int unsigned CB = CTRL_BITS;

   logic          tick;
   logic          empty;
   logic          ld;
   logic          ld_ctrl;
   logic [DW-1:0] ld_bits;

   dsl_prescaler #(
      .DIV_R0 (DIV_R0),
      .DIV_R1 (DIV_R1),
      .DIV_R2 (DIV_R2),
      .DIV_R3 (DIV_R3)
   ) presc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .tick     (tick)
   );

   always_comb begin
      ld      = empty && (fct_req || tx_valid);
      ld_ctrl = fct_req || tx_word[DW];
      ld_bits = '0;
      if (fct_req) begin
         ld_bits[CB-1:0] = CTRL_FCT;
      end else if (tx_word[DW]) begin
         ld_bits[CB-1:0] = tx_word[0] ? CTRL_EEP : CTRL_EOP;
      end else begin
         ld_bits = tx_word[DW-1:0];
      end
   end

   assign fct_ready = empty;
   assign tx_ready  = empty && !fct_req;

   dsl_tx_shift #(
      .DW (DW)
   ) shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ld      (ld),
      .ld_ctrl (ld_ctrl),
      .ld_bits (ld_bits),
      .empty   (empty),
      .d_out   (tx_d),
      .s_out   (tx_s)
   );

   dsl_rx_decode #(
      .DW   (DW),
      .SYNC (SYNC_STAGES)
   ) rx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_in     (rx_d),
      .s_in     (rx_s),
      .rx_valid (rx_valid),
      .rx_word  (rx_word),
      .rx_fct   (rx_fct),
      .par_err  (rx_par_err)
   );
endmodule

// File: tb/dsl_link_codec_tb_top.sv
`timescale 1ns/1ps
module dsl_link_codec_tb_top;
   localparam int DIVS [4] = '{2, 4, 20, 40};
   localparam int NV = 12;
   // {stimulus[19:10], expected receive log entry[9:0]}; stimulus bit 9 = token request
   localparam logic [19:0] VEC [NV] = '{
      {10'h000, 10'h000}, {10'h0FF, 10'h0FF}, {10'h0A5, 10'h0A5},
      {10'h200, 10'h200}, {10'h001, 10'h001}, {10'h100, 10'h100},
      {10'h080, 10'h080}, {10'h101, 10'h101}, {10'h1FE, 10'h100},
      {10'h1AB, 10'h101}, {10'h200, 10'h200}, {10'h03C, 10'h03C}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [8:0] tx_word = '0;
   logic       fct_req = 1'b0;
   logic       fct_ready;
   logic       tx_d, tx_s;
   logic       rx_valid, rx_fct, rx_par_err;
   logic [8:0] rx_word;
   logic       inj = 1'b0;
   logic       bd = 1'b0, bs = 1'b0;
   logic       ipar = 1'b0;
   wire        rx_d_w = inj ? bd : tx_d;
   wire        rx_s_w = inj ? bs : tx_s;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int tn = 0;
   int rn = 0;
   int r2_bad = 0;
   int tx_cyc [4096];
   logic tx_bit [4096];
   logic [9:0] rlog [256];
   logic pd = 1'b0, ps = 1'b0;
   logic mon_en = 1'b0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   dsl_link_codec dut_i (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_word(tx_word),
      .fct_req(fct_req), .fct_ready(fct_ready),
      .tx_d(tx_d), .tx_s(tx_s), .rx_d(rx_d_w), .rx_s(rx_s_w),
      .rx_valid(rx_valid), .rx_word(rx_word), .rx_fct(rx_fct),
      .rx_par_err(rx_par_err)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (mon_en) begin
         if (tx_d !== pd || tx_s !== ps) begin
            if (tx_d !== pd && tx_s !== ps) r2_bad = r2_bad + 1;
            if (tn < 4096) begin
               tx_cyc[tn] = cyc;
               tx_bit[tn] = tx_d;
               tn = tn + 1;
            end
         end
         pd = tx_d;
         ps = tx_s;
         if (rx_valid && rn < 256) begin rlog[rn] = {1'b0, rx_word}; rn = rn + 1; end
         if (rx_fct && rn < 256)   begin rlog[rn] = 10'h200; rn = rn + 1; end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      mon_en = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      pd = 1'b0; ps = 1'b0; tn = 0; rn = 0; ipar = 1'b0;
      mon_en = 1'b1;
   endtask

   task automatic send(input logic [9:0] w);
      @(negedge clk);
      if (w[9]) fct_req = 1'b1;
      else begin tx_valid = 1'b1; tx_word = w[8:0]; end
      while (!(w[9] ? fct_ready : tx_ready)) @(negedge clk);
      @(negedge clk);
      fct_req = 1'b0;
      tx_valid = 1'b0;
   endtask

   task automatic inj_bit(input logic b, input int h);
      @(negedge clk);
      if (b == bd) bs = ~bs;
      bd = b;
      repeat (h - 1) @(negedge clk);
   endtask

   task automatic inj_char(input logic ctrl, input logic [7:0] pl, input logic bad,
                           input int hold, input logic last_quick);
      int n;
      logic acc;
      n = ctrl ? 2 : 8;
      acc = 1'b0;
      inj_bit(~(ipar ^ ctrl) ^ bad, hold);
      inj_bit(ctrl, hold + 2);
      for (int i = 0; i < n; i++) begin
         acc = acc ^ pl[i];
         if (last_quick && i == n - 1) inj_bit(pl[i], 1);
         else inj_bit(pl[i], hold + (i % 3));
      end
      ipar = acc;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1 tx lines in reset", {tx_d, tx_s}, 2'b00);
      chk("R1 rx outputs in reset", {rx_valid, rx_fct, rx_par_err}, 3'b000);
      do_reset();
      chk("R1 ready after reset", {tx_ready, fct_ready}, 2'b11);
      chk("R1 lines after reset", {tx_d, tx_s}, 2'b00);

      // Vector walk at rate 1, transmitter looped back to receiver
      rate_sel = 2'd1;
      for (int v = 0; v < NV; v++) send(VEC[v][19:10]);
      repeat (200) @(negedge clk);
      chk("R9 receive count", rn, NV);
      for (int v = 0; v < NV; v++)
         chk(VEC[v][9] | VEC[v][8] ? "R5 R9 control echo" : "R9 data echo", rlog[v], VEC[v][9:0]);
      begin
         int idx;
         logic ep;
         idx = 0;
         ep = 1'b0;
         for (int v = 0; v < NV; v++) begin
            logic ctrl;
            logic [7:0] pay;
            int n;
            int bad;
            logic acc;
            ctrl = VEC[v][19] | VEC[v][18];
            if (VEC[v][19]) begin pay = 8'h00; n = 2; end
            else if (VEC[v][18]) begin pay = VEC[v][10] ? 8'h02 : 8'h01; n = 2; end
            else begin pay = VEC[v][17:10]; n = 8; end
            bad = 0;
            if (tx_bit[idx] !== ~(ep ^ ctrl)) bad = bad + 1;
            if (tx_bit[idx + 1] !== ctrl) bad = bad + 1;
            acc = 1'b0;
            for (int i = 0; i < n; i++) begin
               if (tx_bit[idx + 2 + i] !== pay[i]) bad = bad + 1;
               acc = acc ^ pay[i];
            end
            chk("R3 R4 R5 character bits", bad, 0);
            ep = acc;
            idx = idx + 2 + n;
         end
         chk("R3 total bit count", tn, idx);
      end
      begin
         int gaps;
         gaps = 0;
         for (int i = 1; i < tn; i++)
            if (tx_cyc[i] - tx_cyc[i - 1] != DIVS[1]) gaps = gaps + 1;
         chk("R8 back-to-back bit spacing", gaps, 0);
      end
      chk("R2 one line changes per bit", r2_bad, 0);

      // R6: token request wins over a pending data word
      do_reset();
      rate_sel = 2'd0;
      @(negedge clk);
      fct_req = 1'b1;
      tx_valid = 1'b1;
      tx_word = 9'h077;
      #1;
      chk("R6 tx_ready low under token request", tx_ready, 1'b0);
      while (!fct_ready) @(negedge clk);
      @(negedge clk);
      fct_req = 1'b0;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (100) @(negedge clk);
      chk("R6 token delivered first", rlog[0], 10'h200);
      chk("R6 data delivered second", rlog[1], 10'h077);

      // R7: bit period per rate selection
      for (int r = 0; r < 4; r++) begin
         int k;
         @(negedge clk);
         rate_sel = 2'(r);
         k = tn;
         send(10'h0C3);
         while (tn < k + 10) @(negedge clk);
         chk("R7 bit period", tx_cyc[k + 1] - tx_cyc[k], DIVS[r]);
         repeat (5) @(negedge clk);
      end

      // R11: receiver driven directly with uneven bit lengths
      do_reset();
      inj = 1'b1;
      bd = 1'b0;
      bs = 1'b0;
      inj_char(1'b0, 8'h5A, 1'b0, 3, 1'b0);
      inj_char(1'b1, 8'h00, 1'b0, 7, 1'b0);
      inj_char(1'b1, 8'h01, 1'b0, 4, 1'b0);
      repeat (10) @(negedge clk);
      chk("R11 uneven bits count", rn, 3);
      chk("R11 data", rlog[0], 10'h05A);
      chk("R11 token", rlog[1], 10'h200);
      chk("R11 end of packet", rlog[2], 10'h100);

      // R9: result latency after the last bit edge
      inj_char(1'b0, 8'h3C, 1'b0, 2, 1'b1);
      @(negedge clk);
      chk("R9 no result one cycle after last edge", rx_valid, 1'b0);
      @(negedge clk);
      chk("R9 no result two cycles after last edge", rx_valid, 1'b0);
      @(negedge clk);
      chk("R9 result three cycles after last edge", {rx_valid, rx_word}, {1'b1, 9'h03C});
      @(negedge clk);
      chk("R9 result is a single pulse", rx_valid, 1'b0);

      // R10: parity failure latches and blocks delivery
      chk("R10 no error before bad parity", rx_par_err, 1'b0);
      inj_char(1'b0, 8'h11, 1'b1, 3, 1'b0);
      repeat (10) @(negedge clk);
      chk("R10 error latched", rx_par_err, 1'b1);
      chk("R10 failing character not delivered", rn, 4);
      inj_char(1'b0, 8'h22, 1'b0, 3, 1'b0);
      inj_char(1'b1, 8'h00, 1'b0, 3, 1'b0);
      repeat (10) @(negedge clk);
      chk("R10 later characters dropped", rn, 4);
      chk("R10 error still latched", rx_par_err, 1'b1);
      do_reset();
      chk("R1 reset clears parity error", rx_par_err, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule